// File: doc/BRIEF.md
# Digital Oscillator Frequency Trim

This block corrects a crystal timebase of nominally 32.768 kHz without touching the crystal. Before the divider chain counts the raw oscillator-rate enable, the block drops a few enable pulses or slips in a few extra ones. The result is a corrected enable stream and a 1 Hz tick derived from it. A correction is applied once per window of input pulses. With the default window of 100,000 pulses, one pulse per window is 10 ppm, so the three-bit trim code spans zero and plus or minus 10, 20 or 30 ppm.

The trim code comes from a plain register input. The block takes it in only at a window boundary, so a write that lands mid-window starts to act from the next window. The system clock runs much faster than the oscillator enable, which leaves idle cycles between input pulses where an extra enable can be placed without merging two pulses.

Top module: `osc_trim`

## Requirements
- R1: While rst_ni is low, cnt_en_o and tick_o are 0. After release the window index is 0 and the active correction is none, so the first window passes exactly WIN_LEN enables.
- R2: trim_i[2] picks the direction (1 adds pulses, 0 skips pulses). trim_i[1:0] is the magnitude m in pulses per window. Codes 3'b000 and 3'b100 mean no correction. At the default WIN_LEN of 100,000, one pulse is 10 ppm.
- R3: In skip mode with magnitude m, the input pulses at window indices 0 to m-1 give no output enable, so the window yields WIN_LEN-m enables.
- R4: In add mode with magnitude m, every input pulse passes. In addition, m extra enables are produced on the first m cycles with osc_en_i low after the window starts, so the window yields WIN_LEN+m enables.
- R5: An inserted enable only ever stands in a cycle whose osc_en_i is low. Each input pulse gives at most one output enable, so pulses are never merged.
- R6: trim_i is sampled only with the input pulse at window index WIN_LEN-1. It becomes the active correction for the window that follows. A value present at any other time has no effect.
- R7: While the active magnitude is zero, cnt_en_o is an exact one-cycle delayed copy of osc_en_i.
- R8: tick_o is a one-cycle pulse that coincides with every DIV_RATIO-th output enable. With zero trim it therefore comes once every 32,768 input pulses at the defaults.
- R9: cnt_en_o is registered. An enable appears exactly one clock after the cycle of its input pulse or of its insertion.
- R10: If osc_en_i is never high on two consecutive cycles and WIN_LEN is at least 8, all insertions of a window finish inside that window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| osc_en_i | input | 1 | Raw oscillator-rate enable, one cycle per oscillator period |
| trim_i | input | 3 | Trim code: bit 2 direction, bits 1:0 magnitude |
| cnt_en_o | output | 1 | Corrected enable stream |
| tick_o | output | 1 | Corrected 1 Hz tick |

## Verification
The assertions take for granted that osc_en_i is a single-cycle strobe with at least one low cycle after it. They also take for granted that the window is much longer than the largest magnitude, so that a window boundary is never hidden inside a skip or add burst. The stimulus places each input pulse after a random gap of one to three idle cycles. It runs with a short window and divider so that many boundaries occur. It forces a chosen code at every boundary pulse, so all eight codes appear, and it changes trim_i at random in between to show that mid-window writes are ignored.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;
  localparam int TRIM_W = 3;

  typedef struct packed {
    logic       add;
    logic [1:0] mag;
  } trim_t;

  function automatic logic [1:0] add_count(trim_t t);
    return t.add ? t.mag : 2'd0;
  endfunction
endpackage

// File: rtl/osc_trim_window.sv
module osc_trim_window
  import osc_trim_pkg::*;
#(
  parameter int WIN_LEN = 100000,
  localparam int WIN_W = $clog2(WIN_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             osc_en_i,
  input  trim_t            trim_i,
  output logic [WIN_W-1:0] win_idx_o,
  output trim_t            act_o,
  output logic             win_last_o
);
  localparam logic [WIN_W-1:0] LAST_IDX = WIN_W'(WIN_LEN - 1);

  logic [WIN_W-1:0] win_q;
  trim_t            act_q;
  logic             win_last;

  assign win_last = osc_en_i && (win_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      act_q <= '0;
    end else if (osc_en_i) begin
      win_q <= win_last ? '0 : win_q + WIN_W'(1);
      if (win_last) act_q <= trim_i;
    end
  end

  assign win_idx_o  = win_q;
  assign act_o      = act_q;
  assign win_last_o = win_last;
endmodule

// File: rtl/osc_trim_corr.sv
module osc_trim_corr
  import osc_trim_pkg::*;
#(
  parameter int WIN_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             osc_en_i,
  input  logic [WIN_W-1:0] win_idx_i,
  input  trim_t            act_i,
  input  logic             load_i,
  input  trim_t            next_i,
  output logic             corr_en_o,
  output logic             cnt_en_o
);
  logic [1:0] add_left_q;
  logic       skip_hit;
  logic       ins_en;
  logic       cnt_en_q;

  // skip the first m pulses of a window
  assign skip_hit  = !act_i.add && (win_idx_i < WIN_W'(act_i.mag));
  // add only on idle cycles
  assign ins_en    = !osc_en_i && (add_left_q != 2'd0);
  assign corr_en_o = osc_en_i ? !skip_hit : ins_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      add_left_q <= 2'd0;
      cnt_en_q   <= 1'b0;
    end else begin
      cnt_en_q <= corr_en_o;
      if (load_i)      add_left_q <= add_count(next_i);
      else if (ins_en) add_left_q <= add_left_q - 2'd1;
    end
  end

  assign cnt_en_o = cnt_en_q;
endmodule

// File: rtl/osc_trim_div.sv
module osc_trim_div #(
  parameter int DIV_RATIO = 32768,
  localparam int DIV_W = $clog2(DIV_RATIO)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;
  logic             tick_q;

  generate
    if ((DIV_RATIO & (DIV_RATIO - 1)) == 0) begin : g_pow2
      assign wrap = en_i && (&cnt_q);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   cnt_q <= '0;
        else if (en_i) cnt_q <= cnt_q + DIV_W'(1);
      end
    end else begin : g_cmp
      localparam logic [DIV_W-1:0] LAST_CNT = DIV_W'(DIV_RATIO - 1);
      assign wrap = en_i && (cnt_q == LAST_CNT);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   cnt_q <= '0;
        else if (en_i) cnt_q <= wrap ? '0 : cnt_q + DIV_W'(1);
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= wrap;
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/osc_trim.sv
module osc_trim
  import osc_trim_pkg::*;
#(
  parameter int WIN_LEN   = 100000,
  parameter int DIV_RATIO = 32768,
  localparam int WIN_W = $clog2(WIN_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              osc_en_i,
  input  logic [TRIM_W-1:0] trim_i,
  output logic              cnt_en_o,
  output logic              tick_o
);
  trim_t            trim_in;
  trim_t            act;
  logic [WIN_W-1:0] win_idx;
  logic             win_last;
  logic             corr_en;

  assign trim_in = trim_t'(trim_i);

  osc_trim_window #(.WIN_LEN(WIN_LEN)) u_window (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .osc_en_i   (osc_en_i),
    .trim_i     (trim_in),
    .win_idx_o  (win_idx),
    .act_o      (act),
    .win_last_o (win_last)
  );

  osc_trim_corr #(.WIN_W(WIN_W)) u_corr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .osc_en_i  (osc_en_i),
    .win_idx_i (win_idx),
    .act_i     (act),
    .load_i    (win_last),
    .next_i    (trim_in),
    .corr_en_o (corr_en),
    .cnt_en_o  (cnt_en_o)
  );

  osc_trim_div #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (corr_en),
    .tick_o (tick_o)
  );
endmodule

// File: rtl/osc_trim_chk.sv
module osc_trim_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       osc_en_i,
  input logic       cnt_en_o,
  input logic       tick_o,
  input logic       act_add,
  input logic [1:0] act_mag,
  input logic       win_last
);
  AST_TICK_ON_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> cnt_en_o) else $error("tick without enable"); // R8

  AST_IN_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_en_i |=> !osc_en_i) else $error("input pulses adjacent"); // R10

  AST_SKIP_NO_INS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_en_i && !act_add) |=> !cnt_en_o) else $error("insert in skip mode"); // R3

  AST_ADD_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_en_i && act_add) |=> cnt_en_o) else $error("pulse dropped in add mode"); // R4

  AST_ZERO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_en_i && act_mag == 2'd0) |=> !cnt_en_o) else $error("insert at zero trim"); // R7

  AST_LAST_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_last |=> cnt_en_o) else $error("last pulse lost"); // R9

  AST_ACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_last |=> ($stable(act_add) && $stable(act_mag))) else $error("trim changed mid-window"); // R6
endmodule

bind osc_trim osc_trim_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .osc_en_i (osc_en_i),
  .cnt_en_o (cnt_en_o),
  .tick_o   (tick_o),
  .act_add  (act.add),
  .act_mag  (act.mag),
  .win_last (win_last)
);

// File: tb/osc_trim_tb.sv
`timescale 1ns/1ps
module osc_trim_tb;
  localparam int LEN  = 20;
  localparam int DIV  = 8;
  localparam int NWIN = 40;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       osc_en;
  logic [2:0] trim;
  logic       cnt_en;
  logic       tick;

  always #4 clk = ~clk;

  osc_trim #(.WIN_LEN(LEN), .DIV_RATIO(DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .osc_en_i(osc_en), .trim_i(trim),
    .cnt_en_o(cnt_en), .tick_o(tick)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  int m_win = 0, m_add = 0, m_mag = 0, m_left = 0, m_div = 0, m_pulses = 0;
  bit exp_en, exp_tick, have_exp = 0;
  string exp_req;
  int attr_win = 0;
  int obs_cnt[NWIN+1];
  int bnd_trim[NWIN+1];
  int tot_en = 0, tot_tick = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(bit osc, logic [2:0] t);
    bit en, tk;
    if (have_exp) begin
      chk(cnt_en == exp_en, exp_req, int'(cnt_en), int'(exp_en)); // R9 latency
      chk(tick == exp_tick, "R8 tick", int'(tick), int'(exp_tick));
      if (cnt_en) begin obs_cnt[attr_win]++; tot_en++; end
      if (tick) tot_tick++;
    end
    osc_en = osc;
    trim   = t;
    en = 0;
    if (osc) begin
      en = !(m_add == 0 && m_win < m_mag);
      exp_req = (m_mag == 0) ? "R7 pass" : (m_add != 0 ? "R4 add pass" : "R3 skip");
      attr_win = m_pulses / LEN;
      if (m_win == LEN - 1) begin
        m_win = 0;
        m_add = int'(t[2]);
        m_mag = int'(t[1:0]);
        m_left = t[2] ? int'(t[1:0]) : 0;
        if (attr_win + 1 <= NWIN) bnd_trim[attr_win+1] = int'(t);
      end else m_win++;
      m_pulses++;
    end else begin
      attr_win = m_pulses / LEN;
      exp_req = (m_mag == 0) ? "R7 idle" : (m_add != 0 ? "R4/R5 insert" : "R3 idle");
      if (m_left > 0) begin en = 1; m_left--; end
    end
    tk = 0;
    if (en) begin
      if (m_div == DIV - 1) begin m_div = 0; tk = 1; end
      else m_div++;
    end
    exp_en = en;
    exp_tick = tk;
    have_exp = 1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [2:0] tcur;
    foreach (obs_cnt[i]) begin obs_cnt[i] = 0; bnd_trim[i] = 0; end
    rst_n = 0; osc_en = 0; trim = 3'b111;
    @(negedge clk);
    osc_en = 1;
    @(negedge clk);
    osc_en = 0;
    @(negedge clk);
    chk(cnt_en == 0, "R1 reset cnt_en", int'(cnt_en), 0);
    chk(tick == 0, "R1 reset tick", int'(tick), 0);
    rst_n = 1;
    @(negedge clk);
    chk(cnt_en == 0 && tick == 0, "R1 after release", int'({cnt_en, tick}), 0);

    tcur = 3'b011;
    for (int p = 0; p < NWIN * LEN; p++) begin
      if (p % LEN == LEN - 1) tcur = 3'((p / LEN * 3 + 1) % 8);
      step(1'b1, tcur);
      for (int g = 0; g < $urandom_range(1, 3); g++) begin
        // mid-window writes must be ignored (R6)
        if ($urandom_range(0, 5) == 0) tcur = 3'($urandom_range(0, 7));
        step(1'b0, tcur);
      end
    end
    for (int i = 0; i < 4; i++) step(1'b0, tcur);

    chk(obs_cnt[0] == LEN, "R1 first window", obs_cnt[0], LEN);
    for (int w = 1; w < NWIN; w++) begin
      int m, e;
      m = bnd_trim[w] % 4;
      e = (bnd_trim[w] >= 4) ? LEN + m : LEN - m;
      chk(obs_cnt[w] == e, $sformatf("R2/R3/R4/R6/R10 window %0d code %0d", w, bnd_trim[w]),
          obs_cnt[w], e);
    end
    chk(tot_tick == tot_en / DIV, "R8 tick total", tot_tick, tot_en / DIV);
    finish_run();
  end
endmodule